// File: doc/BRIEF.md
# Bus-Cycle Change-Detect Reporter

This block sits after a packet decoder on a slot-car style control bus. Each decoded packet arrives as a word, a bit length and a one-cycle valid strobe. Packets whose length marks them as data fill a per-cycle buffer in arrival order. A packet of the boundary length closes the cycle. At that point the buffered words are snapshotted and, depending on the reporting mode, printed as hexadecimal ASCII text on a byte stream with a valid/ready handshake.

A second byte input carries line-terminated host commands. These switch between live mode, which prints every cycle, and change-only mode, which prints a cycle only when it differs from the last stored copy. The record terminator shows which mode produced the record. Serial line coding and packet decoding are outside this block.

Top module: `cycle_reporter`

## Requirements
- R1: After reset, out_valid is low and the block is in change-only mode, so the first record ends with a line feed (0x0A).
- R2: A packet with pkt_len of 5 or less has no effect on the buffer, on the stored copy or on the output.
- R3: Packets with pkt_len above 5 and not equal to 13 fill buffer slots 0 to 9 in arrival order. Packets after the tenth in a cycle are dropped. A slot not written in a cycle keeps its earlier value.
- R4: A packet with pkt_len equal to 13 closes the cycle. The record it produces carries slots 0 to 9 as they stood at that packet, and collection restarts at slot 0.
- R5: Each word is printed as the bytes "0x", then lowercase hexadecimal digits with leading zeros removed (a zero word prints a single "0"), then a space (0x20). Every record starts with the byte "0".
- R6: In live mode every boundary produces a record ending in '*' (0x2A), and the stored copy is not refreshed.
- R7: In change-only mode a record is produced only when at least one of the 10 slots differs from the stored copy. It ends in a line feed, and the stored copy takes the slot values at every such boundary.
- R8: A line feed that arrives while more than 3 command bytes are buffered ends a command and empties the buffer. A first byte of 'A' (0x41) selects live mode and 'C' (0x43) selects change-only mode; any other first byte changes nothing. A line feed that arrives with 3 or fewer bytes buffered is buffered like any other byte.
- R9: An escape byte (0x1B) empties the command buffer and becomes its first byte.
- R10: The command buffer holds at most 8 bytes. Further bytes are discarded, and a line feed still ends the command.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_byte holds its value.
- R12: A boundary that arrives while a record is still being sent produces no record and leaves the stored copy unchanged. Collection still restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Decoded packet strobe, one cycle per packet |
| pkt_word | input | 16 | Decoded packet bits |
| pkt_len | input | 5 | Packet bit length |
| cmd_valid | input | 1 | Host command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| out_valid | output | 1 | Text byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | ASCII text byte |

## Verification
The assertions assume that pkt_valid and cmd_valid are single-cycle strobes, one packet or byte at a time, and that mode changes come only from the command input. They also assume that a record is started only by a boundary packet. The stall property assumes that out_ready may drop at any time, including on the first byte of a record. The stimulus raises each valid for exactly one clock, separated by idle cycles, and moves out_ready between edges. Commands are sent only while no record is being sent, so a record always uses the mode that was in force at its boundary.

// File: rtl/crr_pkg.sv
package crr_pkg;

  typedef enum logic [2:0] {
    PH_ZERO,
    PH_X,
    PH_DIG,
    PH_SP,
    PH_TERM
  } fmt_ph_e;

  localparam logic [7:0] CH_ESC  = 8'h1B;
  localparam logic [7:0] CH_LF   = 8'h0A;
  localparam logic [7:0] CH_LIVE = 8'h41;
  localparam logic [7:0] CH_DIFF = 8'h43;
  localparam logic [7:0] CH_STAR = 8'h2A;
  localparam logic [7:0] CH_SP   = 8'h20;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [7:0] CH_X    = 8'h78;

  // lowercase hex digit for one nibble
  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h57 + {4'h0, n});
  endfunction

endpackage

// File: rtl/crr_cmd.sv
module crr_cmd #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       live
);
  localparam int CW = $clog2(DEPTH + 1);

  // only the first byte decides the command, so only it and the fill level are kept
  logic [CW-1:0] fill;
  logic [7:0]    head;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
      head <= '0;
      live <= 1'b0;
    end else if (cmd_valid) begin
      if (cmd_byte == crr_pkg::CH_ESC) begin
        head <= crr_pkg::CH_ESC;
        fill <= CW'(1);
      end else if (cmd_byte == crr_pkg::CH_LF && fill > CW'(3)) begin
        if (head == crr_pkg::CH_LIVE)      live <= 1'b1;
        else if (head == crr_pkg::CH_DIFF) live <= 1'b0;
        fill <= '0;
      end else if (fill < CW'(DEPTH)) begin
        if (fill == '0) head <= cmd_byte;
        fill <= fill + CW'(1);
      end
    end
  end

endmodule

// File: rtl/crr_collect.sv
module crr_collect #(
  parameter int WORD_W    = 16,
  parameter int N_WORDS   = 10,
  parameter int LEN_W     = 5,
  parameter int BOUND_LEN = 13,
  parameter int SHORT_MAX = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pkt_valid,
  input  logic [WORD_W-1:0]         pkt_word,
  input  logic [LEN_W-1:0]          pkt_len,
  input  logic                      live,
  input  logic                      busy,
  output logic                      start,
  output logic                      term_live,
  output logic [N_WORDS*WORD_W-1:0] snap
);
  localparam int IW = $clog2(N_WORDS + 1);

  logic [WORD_W-1:0] cur    [N_WORDS];
  logic [WORD_W-1:0] prev   [N_WORDS];
  logic [WORD_W-1:0] snap_r [N_WORDS];
  logic [IW-1:0]     slot;
  logic              is_bnd, is_dat, differs;

  assign is_bnd = pkt_valid && (pkt_len == LEN_W'(BOUND_LEN));
  assign is_dat = pkt_valid && (pkt_len > LEN_W'(SHORT_MAX)) && !is_bnd;

  always_comb begin
    differs = 1'b0;
    for (int i = 0; i < N_WORDS; i++)
      if (cur[i] != prev[i]) differs = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      start     <= 1'b0;
      term_live <= 1'b0;
      for (int i = 0; i < N_WORDS; i++) begin
        cur[i]    <= '0;
        prev[i]   <= '0;
        snap_r[i] <= '0;
      end
    end else begin
      start <= 1'b0;
      if (is_dat && slot < IW'(N_WORDS)) begin
        cur[slot] <= pkt_word;
        slot      <= slot + IW'(1);
      end
      if (is_bnd) begin
        slot <= '0;
        if (!busy) begin
          for (int i = 0; i < N_WORDS; i++) begin
            snap_r[i] <= cur[i];
            if (!live) prev[i] <= cur[i];
          end
          start     <= live || differs;
          term_live <= live;
        end
      end
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_snap
    assign snap[g*WORD_W +: WORD_W] = snap_r[g];
  end

endmodule

// File: rtl/crr_fmt.sv
module crr_fmt #(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      term_live,
  input  logic [N_WORDS*WORD_W-1:0] snap,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [7:0]                out_byte
);
  import crr_pkg::*;

  localparam int NIB = WORD_W / 4;
  localparam int DW  = (NIB > 1) ? $clog2(NIB) : 1;
  localparam int IW  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [WORD_W-1:0] wd [N_WORDS];
  fmt_ph_e           ph, n_ph;
  logic [IW-1:0]     widx, n_w;
  logic [DW-1:0]     dpos, n_d;
  logic              busy, n_busy, adv, live_q;
  logic [7:0]        n_byte;

  always_comb
    for (int i = 0; i < N_WORDS; i++) wd[i] = snap[i*WORD_W +: WORD_W];

  // index of the most significant non-zero nibble, 0 for a zero word
  function automatic logic [DW-1:0] top_nib(input logic [WORD_W-1:0] w);
    logic [DW-1:0] t;
    t = '0;
    for (int k = 0; k < NIB; k++)
      if (w[k*4 +: 4] != 4'h0) t = DW'(k);
    return t;
  endfunction

  always_comb begin
    n_ph = ph; n_w = widx; n_d = dpos; n_busy = busy; adv = 1'b0;
    if (!busy) begin
      if (start) begin
        n_busy = 1'b1; n_ph = PH_ZERO; n_w = '0; n_d = '0; adv = 1'b1;
      end
    end else if (out_ready) begin
      adv = 1'b1;
      unique case (ph)
        PH_ZERO: n_ph = PH_X;
        PH_X: begin
          n_ph = PH_DIG;
          n_d  = top_nib(wd[widx]);
        end
        PH_DIG: if (dpos == '0) n_ph = PH_SP; else n_d = dpos - DW'(1);
        PH_SP: begin
          if (widx == IW'(N_WORDS - 1)) n_ph = PH_TERM;
          else begin
            n_w  = widx + IW'(1);
            n_ph = PH_ZERO;
          end
        end
        PH_TERM: n_busy = 1'b0;
        default: n_busy = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (n_ph)
      PH_ZERO: n_byte = CH_ZERO;
      PH_X:    n_byte = CH_X;
      PH_DIG:  n_byte = hex_char(wd[n_w][n_d*4 +: 4]);
      PH_SP:   n_byte = CH_SP;
      PH_TERM: n_byte = live_q ? CH_STAR : CH_LF;
      default: n_byte = CH_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ph       <= PH_ZERO;
      widx     <= '0;
      dpos     <= '0;
      live_q   <= 1'b0;
      out_byte <= '0;
    end else if (adv) begin
      busy     <= n_busy;
      ph       <= n_ph;
      widx     <= n_w;
      dpos     <= n_d;
      out_byte <= n_byte;
      if (!busy) live_q <= term_live;
    end
  end

  assign out_valid = busy;

endmodule

// File: rtl/cycle_reporter.sv
module cycle_reporter #(
  parameter int WORD_W    = 16,
  parameter int N_WORDS   = 10,
  parameter int LEN_W     = 5,
  parameter int BOUND_LEN = 13,
  parameter int SHORT_MAX = 5,
  parameter int CMD_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_valid,
  input  logic [WORD_W-1:0] pkt_word,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte
);
  logic                      live_mode;
  logic                      start, term_live;
  logic [N_WORDS*WORD_W-1:0] snap;

  crr_cmd #(.DEPTH(CMD_DEPTH)) u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .live(live_mode)
  );

  crr_collect #(
    .WORD_W(WORD_W), .N_WORDS(N_WORDS), .LEN_W(LEN_W),
    .BOUND_LEN(BOUND_LEN), .SHORT_MAX(SHORT_MAX)
  ) u_collect (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_word(pkt_word), .pkt_len(pkt_len),
    .live(live_mode), .busy(out_valid | start), .start(start), .term_live(term_live),
    .snap(snap)
  );

  crr_fmt #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_fmt (
    .clk(clk), .rst(rst), .start(start), .term_live(term_live), .snap(snap),
    .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte)
  );

endmodule

// File: rtl/cycle_reporter_chk.sv
module cycle_reporter_chk (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       live_mode
);
  import crr_pkg::*;

  function automatic logic text_byte(input logic [7:0] b);
    return (b >= 8'h30 && b <= 8'h39) || (b >= 8'h61 && b <= 8'h66) ||
           b == CH_X || b == CH_SP || b == CH_STAR || b == CH_LF;
  endfunction

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  assert_record_opens_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_byte == CH_ZERO);

  assert_text_only_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> text_byte(out_byte));

  assert_mode_by_line_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(live_mode) |-> $past(cmd_valid) && $past(cmd_byte) == CH_LF);

  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

endmodule

bind cycle_reporter cycle_reporter_chk u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .live_mode(live_mode)
);

// File: tb/sim_cycle_reporter.sv
module sim_cycle_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int NW         = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 6;

  localparam logic [159:0] BASE = {16'hbeef, 16'h0010, 16'h7000, 16'h000c, 16'h0f00,
                                   16'h1234, 16'hffff, 16'h0000, 16'h00ab, 16'h0001};
  // bit 160: record expected in change-only mode; bits 159:0: slot words, slot 0 lowest
  localparam logic [160:0] VEC [NVEC] = '{
    {1'b1, BASE},
    {1'b0, BASE},
    {1'b1, BASE ^ (160'h1 << 144)},
    {1'b0, BASE ^ (160'h1 << 144)},
    {1'b1, 160'h0},
    {1'b0, 160'h0}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        pkt_valid = 1'b0, cmd_valid = 1'b0, out_ready = 1'b1;
  logic [15:0] pkt_word = '0;
  logic [4:0]  pkt_len = '0;
  logic [7:0]  cmd_byte = '0;
  logic        out_valid;
  logic [7:0]  out_byte;

  cycle_reporter u0 (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_word(pkt_word), .pkt_len(pkt_len),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] cap [256];
  int ncap = 0, last_n = 0;
  logic [7:0] last_byte = '0;
  logic [7:0] expb [256];
  int expn = 0;
  logic [15:0] m_cur [NW];
  logic [15:0] m_prev [NW];
  int m_slot = 0;
  bit m_live = 1'b0;

  always @(negedge clk)
    if (out_valid && out_ready && ncap < 256) begin
      cap[ncap] = out_byte;
      ncap++;
    end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [15:0] w, input logic [4:0] l);
    @(posedge clk); #2;
    pkt_word = w; pkt_len = l; pkt_valid = 1'b1;
    @(posedge clk); #2;
    pkt_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(posedge clk); #2;
    cmd_byte = b; cmd_valid = 1'b1;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic send_text(input string s);
    for (int i = 0; i < s.len(); i++) send_cmd(s[i]);
  endtask

  task automatic m_data(input logic [15:0] w, input logic [4:0] l);
    send_pkt(w, l);
    if (l > 5 && l != 13 && m_slot < NW) begin
      m_cur[m_slot] = w;
      m_slot++;
    end
  endtask

  task automatic push(input logic [7:0] b);
    expb[expn] = b;
    expn++;
  endtask

  task automatic add_hex(input logic [15:0] w);
    int top;
    top = 0;
    for (int k = 0; k < 4; k++) if (w[k*4 +: 4] != 4'h0) top = k;
    push(8'h30); push(8'h78);
    for (int k = top; k >= 0; k--) begin
      logic [3:0] n;
      n = w[k*4 +: 4];
      push(n < 4'd10 ? 8'h30 + {4'h0, n} : 8'h61 + {4'h0, n} - 8'd10);
    end
    push(8'h20);
  endtask

  task automatic boundary(input bit dropped);
    bit diff;
    send_pkt(16'h0, 5'd13);
    m_slot = 0;
    if (!dropped) begin
      diff = 1'b0;
      for (int i = 0; i < NW; i++) if (m_cur[i] != m_prev[i]) diff = 1'b1;
      expn = 0;
      if (m_live || diff) begin
        for (int i = 0; i < NW; i++) add_hex(m_cur[i]);
        push(m_live ? 8'h2A : 8'h0A);
      end
      if (!m_live) for (int i = 0; i < NW; i++) m_prev[i] = m_cur[i];
    end
  endtask

  task automatic collect(input string tag);
    int guard, bad;
    guard = 0;
    repeat (4) @(negedge clk);
    while (out_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    check(ncap == expn, tag, "record length", ncap, expn);
    if (ncap == expn) begin
      bad = -1;
      for (int i = 0; i < ncap; i++) if (bad < 0 && cap[i] != expb[i]) bad = i;
      check(bad < 0, tag, "record byte", bad < 0 ? 0 : int'(cap[bad]),
            bad < 0 ? 0 : int'(expb[bad]));
    end
    last_n    = ncap;
    last_byte = (ncap > 0) ? cap[ncap-1] : 8'h00;
    ncap      = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run not finished actual=%0d expected=%0d", WATCHDOG, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin m_cur[i] = '0; m_prev[i] = '0; end
    repeat (3) @(posedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // table walk in change-only mode (R1 default mode, R4, R5, R7)
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < NW; i++) m_data(VEC[v][i*16 +: 16], 5'd16);
      boundary(1'b0);
      collect("R4 R5 R7");
      check((last_n > 0) == VEC[v][160], "R7", "record emitted", last_n > 0, VEC[v][160]);
      if (v == 0) check(last_byte == 8'h0A, "R1", "change-only terminator", last_byte, 8'h0A);
    end

    // R2: short packets are ignored
    m_data(16'h5555, 5'd5);
    m_data(16'h7777, 5'd2);
    boundary(1'b0);
    collect("R2");
    check(last_n == 0, "R2", "record after short packets", last_n, 0);

    // R3: overflow beyond ten words, then a partial cycle keeps old slots
    for (int i = 0; i < 12; i++) m_data(16'h0100 + 16'(i), (i % 2 == 0) ? 5'd6 : 5'd15);
    boundary(1'b0);
    collect("R3 overflow");
    for (int i = 0; i < 3; i++) m_data(16'h0e00 + 16'(i), 5'd16);
    boundary(1'b0);
    collect("R3 partial");

    // R8: short line is buffered, then completes as an 'A' command
    send_text("A\n");
    boundary(1'b0);
    collect("R8 short line");
    check(last_n == 0, "R8", "record after short line", last_n, 0);
    send_text("zz\n");
    m_live = 1'b1;
    boundary(1'b0);
    collect("R6 R8 live");
    check(last_byte == 8'h2A, "R6", "live terminator", last_byte, 8'h2A);
    m_data(16'hcafe, 5'd16);
    boundary(1'b0);
    collect("R6 live second");
    send_text("Cxyz\n");
    m_live = 1'b0;
    boundary(1'b0);
    collect("R6 R7 no refresh in live");
    check(last_n > 0, "R6", "record after return to change-only", last_n > 0, 1);
    boundary(1'b0);
    collect("R7 repeat");

    // R9: escape restarts the buffer, so a leading 'A' is lost
    send_text("AQ");
    send_cmd(8'h1B);
    send_text("QQ\n\n");
    m_data(16'h0042, 5'd16);
    boundary(1'b0);
    collect("R9");
    check(last_byte == 8'h0A, "R9", "mode after escape", last_byte, 8'h0A);

    // R10: long command still applies its first byte
    send_cmd(8'h41);
    for (int i = 0; i < 12; i++) send_cmd(8'h7A);
    send_cmd(8'h0A);
    m_live = 1'b1;
    boundary(1'b0);
    collect("R10");
    check(last_byte == 8'h2A, "R10", "mode after long command", last_byte, 8'h2A);
    send_text("Czzz\n");
    m_live = 1'b0;
    boundary(1'b0);
    collect("R10 back");

    // R11 stall and R12 boundary during a record
    @(posedge clk); #2;
    out_ready = 1'b0;
    for (int i = 0; i < NW; i++) m_data(16'h1000 + 16'(i * 3), 5'd16);
    boundary(1'b0);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(out_valid == 1'b1 && out_byte == 8'h30, "R11", "held byte during stall",
            out_byte, 8'h30);
      @(negedge clk);
    end
    m_data(16'h0abc, 5'd16);
    m_data(16'h0def, 5'd16);
    boundary(1'b1);
    @(posedge clk); #2;
    out_ready = 1'b1;
    collect("R11 R12 stalled record");
    boundary(1'b0);
    collect("R12 after dropped boundary");
    check(last_n > 0, "R12", "record after dropped boundary", last_n > 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule